// File: doc/BRIEF.md
# Single-Clock FIFO with Block-RAM Storage and Registered Bypass

This block is a single-clock first-in first-out queue meant to sit between two pipeline stages of a memory controller and cut the long combinational paths between them. Its storage array is written and read synchronously, so a synthesis tool can map it onto block RAM even at large depths, such as 1024 words of 32 bits.

A word pushed into an empty queue would normally need an extra RAM read cycle before it could be seen. To avoid this, such a word is captured in a bypass register instead. The output word is then picked by a two-input mux whose select is a register. Both data inputs of that mux are registers too: the bypass register and the RAM read-data register. As a result, the latency from push to visible output is one cycle, and no combinational path runs from the write side to the read side.

The producer side pushes with a write strobe that is qualified by a space flag. The consumer side pops with a read strobe that is qualified by a data-valid flag. The current occupancy is exposed as a count.

Top module: `sfifo_bypass`

## Requirements
- R1: A word pushed while the queue is empty is on `rd_data`, with `rd_valid` high, at the first clock edge after the push. A word pushed in the same cycle that the only stored word is popped also appears at that edge.
- R2: Words leave in the order they were accepted. This holds for every mix of pushes, pops, simultaneous push and pop, bypass and RAM paths. `rd_data` always shows the oldest stored word while `rd_valid` is high.
- R3: `fill` equals the number of stored words and never exceeds DEPTH. An accepted push raises it by one and an accepted pop lowers it by one. An accepted push and pop in the same cycle leave it unchanged.
- R4: `wr_ready` is high exactly when `fill` is below DEPTH. A push strobe while `wr_ready` is low is ignored: `fill` does not change and the word never appears at the output.
- R5: `rd_valid` is high exactly when `fill` is non-zero. A pop strobe while `rd_valid` is low is ignored and the queue stays empty.
- R6: While two or more words are stored, an accepted pop leaves `rd_valid` high in the next cycle. Consecutive pops run at one word per cycle with no empty cycle between them.
- R7: A synchronous reset (`rst` high at a clock edge) empties the queue. After it, `fill` is 0, `rd_valid` is low and `wr_ready` is high, whatever the strobes were doing during reset.
- R8: `rd_data` changes only at clock edges. Changing `wr_data` or `wr_en` between two edges has no effect on `rd_data` before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | WIDTH | Word to push |
| wr_en | input | 1 | Push strobe, acted on only when `wr_ready` is high |
| wr_ready | output | 1 | Space available |
| rd_data | output | WIDTH | Oldest stored word |
| rd_valid | output | 1 | A word is available on `rd_data` |
| rd_en | input | 1 | Pop strobe, acted on only when `rd_valid` is high |
| fill | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
The bench targets the moments when the output source changes hands. The first case is a push into an empty queue. A design that routed that word through the RAM would raise `rd_valid` one cycle late. The second case is a push while the last word is popped, and the third is a pop that must start the next RAM read in the same cycle. Getting either of these wrong produces a bubble in `rd_valid`, a duplicated word, or a word delivered out of order. The bench also drives the queue to full and to empty and strobes past each limit. A design without proper guards would overwrite the oldest word or wrap `fill`. Finally, the bench toggles `wr_data` between edges to catch any combinational path from the write side into `rd_data`.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
   // Which register feeds the output mux.
   typedef enum logic {
      SRC_BYPASS = 1'b0,
      SRC_RAM    = 1'b1
   } sfifo_src_e;
endpackage

// File: rtl/sfifo_ram.sv
// Simple dual-port storage: synchronous write, registered synchronous read.
module sfifo_ram #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 1024,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_word,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_word
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_word;
   end

   always_ff @(posedge clk) begin
      if (rd_en) rd_word <= mem[rd_addr];
   end

   // A read never targets the slot being written in the same cycle (order, R2).
   assert_no_rw_collision_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && rd_en) |-> (wr_addr != rd_addr));
endmodule

// File: rtl/sfifo_ctrl.sv
// Occupancy, pointers, flags and the steering of each push.
module sfifo_ctrl #(
   parameter int DEPTH = 1024,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic          wr_ready,
   output logic          rd_valid,
   output logic [LW-1:0] fill,
   output logic          byp_load,
   output logic          ram_we,
   output logic [AW-1:0] ram_waddr,
   output logic          ram_re,
   output logic [AW-1:0] ram_raddr
);
   logic [LW-1:0] level_q, level_d, ram_cnt;
   logic [AW-1:0] wptr_q, rptr_q;
   logic          head_q, head_d;
   logic          push, pop, head_free;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign wr_ready  = (level_q != LW'(DEPTH));
   assign rd_valid  = head_q;
   assign fill      = level_q;

   assign push      = wr_en && wr_ready;
   assign pop       = rd_en && head_q;
   assign ram_cnt   = level_q - LW'(head_q);
   assign head_free = !head_q || (pop && ram_cnt == '0);

   assign byp_load  = push && head_free;
   assign ram_we    = push && !head_free;
   assign ram_re    = pop && (ram_cnt != '0);
   assign ram_waddr = wptr_q;
   assign ram_raddr = rptr_q;

   always_comb begin
      level_d = level_q;
      if (push && !pop)      level_d = level_q + 1'b1;
      else if (pop && !push) level_d = level_q - 1'b1;
      head_d = head_q;
      if (byp_load || ram_re) head_d = 1'b1;
      else if (pop)           head_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q <= '0;
         head_q  <= 1'b0;
         wptr_q  <= '0;
         rptr_q  <= '0;
      end else begin
         level_q <= level_d;
         head_q  <= head_d;
         if (ram_we) wptr_q <= bump(wptr_q);
         if (ram_re) rptr_q <= bump(rptr_q);
      end
   end

   assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
      level_q <= LW'(DEPTH));
   assert_fill_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_ready && rd_en && rd_valid) |=> $stable(fill));
   assert_bypass_latency_R1: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !rd_valid) |=> rd_valid);
   assert_full_ignore_R4: assert property (@(posedge clk) disable iff (rst)
      (!wr_ready && !rd_en) |=> $stable(fill));
   assert_empty_ignore_R5: assert property (@(posedge clk) disable iff (rst)
      (!rd_valid && !wr_en) |=> (!rd_valid && fill == '0));
   assert_valid_level_R5: assert property (@(posedge clk) disable iff (rst)
      rd_valid == (fill != '0));
   assert_no_bubble_R6: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_valid && fill >= LW'(2)) |=> rd_valid);
endmodule

// File: rtl/sfifo_outstage.sv
// Bypass register, source select register and the output mux.
module sfifo_outstage
   import sfifo_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             byp_load,
   input  logic             ram_load,
   input  logic [WIDTH-1:0] ram_word,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] byp_q;
   sfifo_src_e       src_q;

   always_ff @(posedge clk) begin
      if (byp_load) byp_q <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rst)           src_q <= SRC_BYPASS;
      else if (byp_load) src_q <= SRC_BYPASS;
      else if (ram_load) src_q <= SRC_RAM;
   end

   // Both mux data inputs and the select are register outputs (R8).
   assign rd_data = (src_q == SRC_RAM) ? ram_word : byp_q;

   assert_one_source_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot0({byp_load, ram_load}));
endmodule

// File: rtl/sfifo_bypass.sv
module sfifo_bypass #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 1024,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             wr_en,
   output logic             wr_ready,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_valid,
   input  logic             rd_en,
   output logic [LW-1:0]    fill
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("sfifo_bypass: WIDTH must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("sfifo_bypass: DEPTH must be at least 2");
      end
   endgenerate

   logic             byp_load, ram_we, ram_re;
   logic [AW-1:0]    ram_waddr, ram_raddr;
   logic [WIDTH-1:0] ram_word;

   sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
      .wr_ready(wr_ready), .rd_valid(rd_valid), .fill(fill),
      .byp_load(byp_load), .ram_we(ram_we), .ram_waddr(ram_waddr),
      .ram_re(ram_re), .ram_raddr(ram_raddr)
   );

   sfifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
      .clk(clk), .rst(rst), .wr_en(ram_we), .wr_addr(ram_waddr),
      .wr_word(wr_data), .rd_en(ram_re), .rd_addr(ram_raddr),
      .rd_word(ram_word)
   );

   sfifo_outstage #(.WIDTH(WIDTH)) u_out (
      .clk(clk), .rst(rst), .wr_data(wr_data), .byp_load(byp_load),
      .ram_load(ram_re), .ram_word(ram_word), .rd_data(rd_data)
   );
endmodule

// File: tb/tb_sfifo_bypass.sv
module tb_sfifo_bypass;
   localparam int CLK_PERIOD = 10;
   localparam int W  = 16;
   localparam int D  = 8;
   localparam int LW = $clog2(D + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [W-1:0]  wr_data = '0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic          wr_ready, rd_valid;
   logic [W-1:0]  rd_data;
   logic [LW-1:0] fill;

   logic [W-1:0]  model[$];
   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   sfifo_bypass #(.WIDTH(W), .DEPTH(D)) dut (
      .clk(clk), .rst(rst), .wr_data(wr_data), .wr_en(wr_en),
      .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
      .rd_en(rd_en), .fill(fill)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Outputs against the reference queue; called away from the clock edge.
   task automatic check_outputs();
      chk("R5", "rd_valid", 32'(rd_valid), 32'(model.size() != 0));
      chk("R4", "wr_ready", 32'(wr_ready), 32'(model.size() < D));
      chk("R3", "fill",     32'(fill),     32'(model.size()));
      if (model.size() != 0) chk("R2", "rd_data", 32'(rd_data), 32'(model[0]));
   endtask

   // At a falling edge: check, drive, take the rising edge, update the model.
   task automatic step(input bit w, input bit r, input logic [W-1:0] d);
      bit acc_w, acc_r;
      check_outputs();
      wr_en = w; rd_en = r; wr_data = d;
      acc_w = w && (model.size() < D);
      acc_r = r && (model.size() != 0);
      @(posedge clk);
      if (acc_r) void'(model.pop_front());
      if (acc_w) model.push_back(d);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1; wr_en = 1'b1; rd_en = 1'b1; wr_data = 16'hDEAD;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      model.delete();
      chk("R7", "fill after reset",     32'(fill),     32'd0);
      chk("R7", "rd_valid after reset", 32'(rd_valid), 32'd0);
      chk("R7", "wr_ready after reset", 32'(wr_ready), 32'd1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      do_reset();

      // R1: push into empty, visible next edge
      step(1, 0, 16'h1111);
      chk("R1", "valid one cycle after push", 32'(rd_valid), 32'd1);
      chk("R1", "bypassed word", 32'(rd_data), 32'h1111);
      // R1: push while the last word leaves
      step(1, 1, 16'h2222);
      chk("R1", "word replacing last one", 32'(rd_data), 32'h2222);
      step(0, 1, '0);

      // R5: pop on empty is ignored
      step(0, 1, '0);
      chk("R5", "fill after empty pop", 32'(fill), 32'd0);

      // Fill to full, then push past the limit (R4)
      for (int i = 0; i < D; i++) step(1, 0, 16'h3000 + 16'(i));
      chk("R4", "wr_ready at full", 32'(wr_ready), 32'd0);
      step(1, 0, 16'hBAD0);
      chk("R4", "fill after push on full", 32'(fill), 32'(D));

      // R8: write side wiggles between edges do not reach rd_data
      begin
         logic [W-1:0] held;
         held = rd_data;
         wr_data = ~held; wr_en = 1'b1;
         #1;
         chk("R8", "rd_data between edges", 32'(rd_data), 32'(held));
         wr_data = held; #1;
         chk("R8", "rd_data between edges", 32'(rd_data), 32'(held));
         wr_en = 1'b0;
      end

      // Drain back-to-back, no bubble (R6); order checked by step (R2)
      for (int i = 0; i < D; i++) begin
         step(0, 1, '0);
         if (model.size() != 0) chk("R6", "valid during burst pop", 32'(rd_valid), 32'd1);
      end

      // R3: simultaneous push and pop at every partial level
      for (int lvl = 1; lvl < D; lvl++) begin
         while (model.size() < lvl) step(1, 0, 16'h4000 + 16'(model.size()));
         step(1, 1, 16'h5000 + 16'(lvl));
         chk("R3", "fill held on push+pop", 32'(fill), 32'(lvl));
      end
      while (model.size() != 0) step(0, 1, '0);

      // Random traffic in fill-heavy, drain-heavy and balanced phases (R2)
      for (int i = 0; i < 6000; i++) begin
         int ph, pw, pr;
         ph = (i / 400) % 3;
         pw = (ph == 0) ? 80 : (ph == 1) ? 30 : 55;
         pr = (ph == 0) ? 30 : (ph == 1) ? 80 : 55;
         step(($urandom % 100) < pw, ($urandom % 100) < pr, W'($urandom));
      end

      // R7: reset in the middle of traffic
      for (int i = 0; i < 5; i++) step(1, 0, 16'h6000 + 16'(i));
      do_reset();
      step(1, 0, 16'h7777);
      chk("R1", "bypass after reset", 32'(rd_data), 32'h7777);
      step(0, 1, '0);
      check_outputs();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule